// File: doc/BRIEF.md
# DSI Video Frame and Line Sequencer

This block decides what a DSI video-mode transmitter sends, and in what order, for each line and each frame. It does not produce pixels, CRC or ECC. It produces a stream of packet slots. Each slot names a packet kind and the number of payload bytes that packet carries. A downstream packet builder takes each slot through a valid/ready handshake. The sequencer then stays idle for as many byte-clock cycles as the payload is long, and only then offers the next slot.

Frame timing follows an incoming VSYNC pulse. After reset, and at the end of every frame, the sequencer waits in low-power until VSYNC arrives. Vertically, a frame runs through four groups of lines in a fixed order: sync lines, back-porch lines, active lines, then front-porch lines. The sequencer does not transmit the last programmed front-porch line. At that point it drops to low-power and waits for the next VSYNC. Software should therefore program one front-porch line fewer than the video source uses, so that the DSI frame always ends before the next sync.

All horizontal values are byte counts, stored net of packet overhead:

- The sync-active blanking value excludes 14 bytes: two 4-byte short packets plus a 6-byte long-packet wrapper.
- The back-porch value excludes 12 bytes: a blanking packet wrapper plus the active packet wrapper.
- The front-porch value excludes 6 bytes.
- The blank-line value is the total line size less 20 bytes.

Pixel counts convert to bytes at 2, 2.25 or 3 bytes per pixel, depending on the pixel format.

Top module: `dsi_line_sequencer`

## Requirements
- R1: After reset, `lp_mode_o` is 1, `slot_valid_o` is 0 and `timing_err_o` is 0. No slot is offered until `vsync_i` is seen.
- R2: Slot kinds are encoded on `slot_kind_o` as follows: 1 is sync-start, 2 is sync-end, 3 is blanking, 4 is active data. An active line offers six slots in this order, with these lengths:
  - sync-start, length 0
  - blanking, length `cfg_sync_bytes`
  - sync-end, length 0
  - blanking, length `cfg_bporch_bytes`
  - active data, length `cfg_active_bytes`
  - blanking, length `cfg_fporch_bytes`
- R3: A line without active data offers four slots in this order, with these lengths:
  - sync-start, length 0
  - blanking, length `cfg_sync_bytes`
  - sync-end, length 0
  - blanking, length `cfg_blankline_bytes`
- R4: A frame consists of `cfg_sync_lines` sync lines, then `cfg_bporch_lines` back-porch lines, then `cfg_active_lines` active lines, then front-porch lines. A group programmed to zero lines is skipped.
- R5: The number of front-porch lines transmitted is `cfg_fporch_lines` minus one (zero if the register is 0). `lp_mode_o` then rises in the cycle after the gap of the frame's last slot ends.
- R6: While in low-power, no slot is offered, `slot_ready_i` has no effect, and `lp_mode_o` stays 1 until `vsync_i`.
- R7: While `slot_valid_o` is 1 and `slot_ready_i` is 0, the slot stays offered with `slot_kind_o` and `slot_len_o` unchanged.
- R8: A slot is accepted when `slot_valid_o` and `slot_ready_i` are both 1 on a clock edge. After accepting a slot of length N, `slot_valid_o` stays 0 for exactly N cycles and the next slot is offered in the cycle after. A slot of length 0 is followed at once by the next slot.
- R9: A `vsync_i` that arrives while `lp_mode_o` is 0 sets `timing_err_o`. The flag stays set until reset, and the frame restarts from its first line.
- R10: In the cycle after `vsync_i`, the first slot of the frame (sync-start) is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_i | input | 1 | One-cycle frame sync pulse from the video source |
| slot_ready_i | input | 1 | Downstream accepts the offered slot |
| cfg_sync_lines | input | LINE_W | Number of sync lines |
| cfg_bporch_lines | input | LINE_W | Number of back-porch lines |
| cfg_active_lines | input | LINE_W | Number of active lines |
| cfg_fporch_lines | input | LINE_W | Programmed front-porch lines (one is spent in low-power) |
| cfg_sync_bytes | input | BYTE_W | Sync-active blanking payload, net of 14 overhead bytes |
| cfg_bporch_bytes | input | BYTE_W | Back-porch blanking payload, net of 12 overhead bytes |
| cfg_active_bytes | input | BYTE_W | Active data payload bytes |
| cfg_fporch_bytes | input | BYTE_W | Front-porch blanking payload, net of 6 overhead bytes |
| cfg_blankline_bytes | input | BYTE_W | Blank-line combined blanking payload (line total less 20) |
| slot_valid_o | output | 1 | A slot is offered |
| slot_kind_o | output | 3 | Slot kind: 1 sync-start, 2 sync-end, 3 blanking, 4 active |
| slot_len_o | output | BYTE_W | Payload byte count of the offered slot |
| lp_mode_o | output | 1 | Low-power wait for the next VSYNC |
| timing_err_o | output | 1 | Sticky: VSYNC arrived before the low-power wait |

## Verification
The bench covers several awkward cases:

- **Zero-line back porch and single-line front porch.** A design that failed to skip an empty group would emit a stray line or hang. A design that counted the front porch wrongly would send one line too many and never reach low-power in time.
- **Zero-length blanking packets and stalled handshakes.** A design with an off-by-one in its gap counter would open a bubble or swallow a slot. One that let the slot move while waiting for ready would corrupt lengths.
- **VSYNC arriving mid-frame, while a payload gap is still running.** A design that only checked for an idle state would miss the error or leave a stale gap behind. One that failed to restart would continue the old frame.
- **Ready held high during low-power.** This must produce nothing.

// File: rtl/dsi_line_sequencer.sv
module dsi_line_sequencer #(
  parameter int LINE_W = 12,
  parameter int BYTE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_i,
  input  logic              slot_ready_i,
  input  logic [LINE_W-1:0] cfg_sync_lines,
  input  logic [LINE_W-1:0] cfg_bporch_lines,
  input  logic [LINE_W-1:0] cfg_active_lines,
  input  logic [LINE_W-1:0] cfg_fporch_lines,
  input  logic [BYTE_W-1:0] cfg_sync_bytes,
  input  logic [BYTE_W-1:0] cfg_bporch_bytes,
  input  logic [BYTE_W-1:0] cfg_active_bytes,
  input  logic [BYTE_W-1:0] cfg_fporch_bytes,
  input  logic [BYTE_W-1:0] cfg_blankline_bytes,
  output logic              slot_valid_o,
  output logic [2:0]        slot_kind_o,
  output logic [BYTE_W-1:0] slot_len_o,
  output logic              lp_mode_o,
  output logic              timing_err_o
);

  localparam logic [2:0] K_SS     = 3'd1;
  localparam logic [2:0] K_SE     = 3'd2;
  localparam logic [2:0] K_BLANK  = 3'd3;
  localparam logic [2:0] K_ACTIVE = 3'd4;

  localparam logic [2:0] P_SYNC = 3'd0;
  localparam logic [2:0] P_BP   = 3'd1;
  localparam logic [2:0] P_ACT  = 3'd2;
  localparam logic [2:0] P_FP   = 3'd3;
  localparam logic [2:0] P_LP   = 3'd4;

  logic [2:0]        phase_q;
  logic [LINE_W-1:0] line_q;
  logic [2:0]        slot_q;
  logic              drain_q;
  logic [BYTE_W-1:0] drain_cnt_q;
  logic              err_q;

  logic [LINE_W-1:0] fp_emit;
  logic [LINE_W-1:0] grp_lines [4];
  logic [3:0]        nonzero;

  assign fp_emit      = (cfg_fporch_lines == '0) ? '0 : cfg_fporch_lines - LINE_W'(1);
  assign grp_lines[0] = cfg_sync_lines;
  assign grp_lines[1] = cfg_bporch_lines;
  assign grp_lines[2] = cfg_active_lines;
  assign grp_lines[3] = fp_emit;

  for (genvar g = 0; g < 4; g++) begin : g_nz
    assign nonzero[g] = grp_lines[g] != '0;
  end

  function automatic logic [2:0] first_group(input logic [2:0] from, input logic [3:0] nz);
    logic [2:0] r;
    r = P_LP;
    for (int p = 3; p >= 0; p--)
      if (3'(p) >= from && nz[p]) r = 3'(p);
    return r;
  endfunction

  logic              active_line;
  logic [2:0]        last_slot;
  logic              accept;
  logic              line_done;
  logic [LINE_W-1:0] line_next;
  logic              group_done;

  assign active_line = phase_q == P_ACT;
  assign last_slot   = active_line ? 3'd5 : 3'd3;

  always_comb begin
    slot_kind_o = K_BLANK;
    slot_len_o  = '0;
    case (slot_q)
      3'd0: slot_kind_o = K_SS;
      3'd1: slot_len_o  = cfg_sync_bytes;
      3'd2: slot_kind_o = K_SE;
      3'd3: slot_len_o  = active_line ? cfg_bporch_bytes : cfg_blankline_bytes;
      3'd4: begin
        slot_kind_o = K_ACTIVE;
        slot_len_o  = cfg_active_bytes;
      end
      default: slot_len_o = cfg_fporch_bytes;
    endcase
  end

  assign slot_valid_o = (phase_q != P_LP) && !drain_q;
  assign lp_mode_o    = (phase_q == P_LP) && !drain_q;
  assign timing_err_o = err_q;
  assign accept       = slot_valid_o && slot_ready_i;
  assign line_done    = accept && (slot_q == last_slot);
  assign line_next    = line_q + LINE_W'(1);
  assign group_done   = line_next == grp_lines[phase_q[1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= P_LP;
      line_q      <= '0;
      slot_q      <= '0;
      drain_q     <= 1'b0;
      drain_cnt_q <= '0;
      err_q       <= 1'b0;
    end else if (vsync_i) begin
      err_q       <= err_q | !lp_mode_o;
      phase_q     <= first_group(P_SYNC, nonzero);
      line_q      <= '0;
      slot_q      <= '0;
      drain_q     <= 1'b0;
      drain_cnt_q <= '0;
    end else begin
      if (drain_q) begin
        drain_cnt_q <= drain_cnt_q - BYTE_W'(1);
        if (drain_cnt_q == BYTE_W'(1)) drain_q <= 1'b0;
      end
      if (accept) begin
        if (slot_len_o != '0) begin
          drain_q     <= 1'b1;
          drain_cnt_q <= slot_len_o;
        end
        if (line_done) begin
          slot_q <= '0;
          if (group_done) begin
            phase_q <= first_group(phase_q + 3'd1, nonzero);
            line_q  <= '0;
          end else begin
            line_q <= line_next;
          end
        end else begin
          slot_q <= slot_q + 3'd1;
        end
      end
    end
  end

  a_r7_hold_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid_o && !slot_ready_i && !vsync_i) |=>
      (slot_valid_o && $stable(slot_kind_o) && $stable(slot_len_o)));

  a_r8_gap_after_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && slot_len_o != '0 && !vsync_i) |=> !slot_valid_o);

  a_r6_lp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode_o && !vsync_i) |=> lp_mode_o);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err_o |=> timing_err_o);

  a_r9_err_on_early_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_i && !lp_mode_o) |=> timing_err_o);

  a_r10_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_i && cfg_sync_lines != '0) |=> (slot_valid_o && slot_kind_o == K_SS));

endmodule

// File: tb/test_dsi_line_sequencer.sv
module test_dsi_line_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 12;
  localparam int BW = 16;

  logic clk = 0, rst_n = 0, vsync = 0, ready = 0;
  logic [LW-1:0] v_sync, v_bp, v_act, v_fp;
  logic [BW-1:0] h_sync, h_bp, h_act, h_fp, h_blank;
  logic valid, lp, err;
  logic [2:0] kind;
  logic [BW-1:0] len;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsi_line_sequencer #(.LINE_W(LW), .BYTE_W(BW)) i_dsi_line_sequencer (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .slot_ready_i(ready),
    .cfg_sync_lines(v_sync), .cfg_bporch_lines(v_bp), .cfg_active_lines(v_act),
    .cfg_fporch_lines(v_fp), .cfg_sync_bytes(h_sync), .cfg_bporch_bytes(h_bp),
    .cfg_active_bytes(h_act), .cfg_fporch_bytes(h_fp), .cfg_blankline_bytes(h_blank),
    .slot_valid_o(valid), .slot_kind_o(kind), .slot_len_o(len),
    .lp_mode_o(lp), .timing_err_o(err));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int vs, vb, va, vf, hs, hb, ha, hf, hk);
    v_sync = LW'(vs); v_bp = LW'(vb); v_act = LW'(va); v_fp = LW'(vf);
    h_sync = BW'(hs); h_bp = BW'(hb); h_act = BW'(ha); h_fp = BW'(hf); h_blank = BW'(hk);
  endtask

  task automatic pulse_vsync();
    vsync = 1;
    @(negedge clk);
    vsync = 0;
  endtask

  // Called at a negedge where the slot must already be offered.
  task automatic take_slot(input int k, input int n, input int stall, input string req);
    check(valid === 1'b1, {req, " slot offered"}, int'(valid), 1);
    check(kind == 3'(k) && len == BW'(n), {req, " kind*65536+len"},
          int'(kind) * 65536 + int'(len), k * 65536 + n);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(valid && kind == 3'(k) && len == BW'(n), "R7 slot held while not ready",
            int'(kind) * 65536 + int'(len), k * 65536 + n);
    end
    ready = 1;
    @(negedge clk);
    ready = 0;
    for (int i = 0; i < n; i++) begin
      check(!valid, "R8 payload gap", int'(valid), 0);
      @(negedge clk);
    end
  endtask

  task automatic blank_line(input int stall, input string req);
    take_slot(1, 0, stall, req);
    take_slot(3, int'(h_sync), stall, req);
    take_slot(2, 0, stall, req);
    take_slot(3, int'(h_blank), stall, req);
  endtask

  task automatic active_line(input int stall);
    take_slot(1, 0, stall, "R2");
    take_slot(3, int'(h_sync), stall, "R2");
    take_slot(2, 0, stall, "R2");
    take_slot(3, int'(h_bp), stall, "R2");
    take_slot(4, int'(h_act), stall, "R2");
    take_slot(3, int'(h_fp), stall, "R2");
  endtask

  task automatic play_frame(input int stall);
    for (int l = 0; l < int'(v_sync); l++) blank_line(stall, "R4 sync line R3");
    for (int l = 0; l < int'(v_bp); l++) blank_line(stall, "R4 back-porch line R3");
    for (int l = 0; l < int'(v_act); l++) active_line(stall);
    for (int l = 0; l + 1 < int'(v_fp); l++) blank_line(stall, "R5 front-porch line");
    check(lp === 1'b1 && !valid, "R5 low-power after last emitted line", int'(lp), 1);
  endtask

  task automatic t_reset();
    set_cfg(1, 1, 1, 2, 1, 1, 1, 1, 1);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(lp === 1'b1, "R1 lp after reset", int'(lp), 1);
    check(valid === 1'b0, "R1 no slot after reset", int'(valid), 0);
    check(err === 1'b0, "R1 err clear after reset", int'(err), 0);
    ready = 1;
    repeat (8) @(negedge clk);
    check(!valid && lp, "R1 waits for vsync", int'(valid), 0);
    ready = 0;
  endtask

  task automatic t_basic_frame();
    set_cfg(1, 2, 2, 3, 3, 2, 5, 1, 4);
    pulse_vsync();
    check(valid && kind == 3'd1, "R10 first slot after vsync", int'(kind), 1);
    play_frame(0);
    check(err === 1'b0, "R9 no err on clean frame", int'(err), 0);
  endtask

  task automatic t_lp_wait();
    ready = 1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      check(lp && !valid, "R6 idle in low-power, ready ignored", int'(valid), 0);
    end
    ready = 0;
  endtask

  task automatic t_stall_and_skip();
    set_cfg(2, 0, 1, 1, 0, 1, 2, 0, 2);
    pulse_vsync();
    play_frame(2);
  endtask

  task automatic t_zero_fp();
    set_cfg(1, 1, 1, 0, 1, 0, 1, 2, 1);
    pulse_vsync();
    play_frame(0);
  endtask

  task automatic t_early_vsync();
    set_cfg(1, 2, 2, 3, 3, 2, 5, 1, 4);
    pulse_vsync();
    take_slot(1, 0, 0, "R9 pre");
    take_slot(3, 3, 0, "R9 pre");
    // Restart while the slot after the gap is pending.
    pulse_vsync();
    check(err === 1'b1, "R9 err set by early vsync", int'(err), 1);
    check(valid && kind == 3'd1, "R9 frame restarts at sync-start", int'(kind), 1);
    play_frame(0);
    // Restart during an active payload gap.
    pulse_vsync();
    take_slot(1, 0, 0, "R9 pre");
    ready = 1;
    @(negedge clk);
    ready = 0;
    check(!valid, "R8 gap running", int'(valid), 0);
    pulse_vsync();
    check(valid && kind == 3'd1 && len == 0, "R9 restart cancels gap", int'(kind), 1);
    play_frame(1);
    check(err === 1'b1, "R9 err sticky", int'(err), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    set_cfg(1, 1, 1, 2, 1, 1, 1, 1, 1);
    @(negedge clk);
    t_reset();
    t_basic_frame();
    t_lp_wait();
    t_stall_and_skip();
    t_zero_fp();
    t_lp_wait();
    t_early_vsync();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule